// File: doc/BRIEF.md
# Ramp-time zero-average current controller

This block generates the switch command for one leg of a current-controlled inverter. It sees only a one-bit polarity of the current error. The polarity is high while the measured current is above its reference. The block drives a one-bit command in which 1 closes the upper switch; the lower switch is its complement and is driven elsewhere.

The block measures how long the error stays on each side of zero. It also measures the delay from each zero crossing to the switching edge that follows it. It times the next switching edge by scaling last period's delay by the ratio of half the desired switching period to last period's duration on the same side. The division is a ramp: an accumulator adds the previous duration every clock and is compared with the previous delay times the desired half-period. In closed loop, each side of the error settles near half the desired period. This keeps the average error at zero and the switching frequency fixed.

A watchdog forces the command to toggle when the loop stalls, so the controller can start up from any state of the plant.

Top module: `ramp_time_ctrl`

## Requirements
- R1: After reset, sw_o is 0. The held values are seeded on the first clock after reset: both side durations are H (the half-period input) and both delays are floor(H/2).
- R2: err_pol_i passes through two synchronizing flops. A polarity change acts at the third rising clock edge after the input changes. A level held across K clock edges is measured as a duration of K. The first duration after reset counts the clock edges from reset release up to, but not including, the first polarity edge.
- R3: When the polarity rises while sw_o is 1, sw_o goes to 0 on the n-th clock edge after the edge that saw the polarity rise. Here n = ceil(Dh * H / Th), where Dh is the held positive-side delay and Th is the held positive-side duration.
- R4: When the polarity falls while sw_o is 0, sw_o goes to 1 after n = ceil(Dl * H / Tl) edges. Here Dl is the held negative-side delay and Tl is the held negative-side duration.
- R5: A polarity rise while sw_o is 0, or a fall while sw_o is 1, starts no ramp and leaves sw_o unchanged.
- R6: Each polarity edge replaces the held duration of the side that just ended. Each completed ramp replaces the held delay of its side with its own n. Every held value is used by the next ramp on its side only.
- R7: With the same held delay, a longer measured duration gives a shorter next delay. The correction for switching latency comes only from the measurements.
- R8: If 4*H clock edges pass with neither a polarity edge nor a change of sw_o, sw_o toggles. The count then restarts, so the toggle repeats every 4*H edges.
- R9: In closed loop with a plant that integrates up while sw_o is 1 and down while it is 0, the average switching period settles within 5 cycles of 2*H. The average time per period that the polarity is high settles within 5 cycles of H. This holds for equal and for unequal slopes.
- R10: A polarity edge of the opposite side cancels an active ramp, and sw_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_period_i | input | CW | Desired half switching period H, in clock cycles |
| err_pol_i | input | 1 | Current error polarity, 1 while the current is above its reference |
| sw_o | output | 1 | Switch command, 1 closes the upper switch |

## Verification
The hardest state to reach from the ports is a ramp whose exact timing depends on held values that were measured in earlier periods.

The open-loop stimulus builds every held value from known edges. The first low span is counted from reset release. Each later span is a hold length chosen by the bench. A chain of ramps then checks every switching instant to the exact cycle against ceil(delay*H/duration).

A short negative excursion cuts an up-ramp before it ends, to reach the cancel case. The closed-loop runs start from a plant with no crossing at all, so only the watchdog can bring the loop into regulation.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int unsigned SIDES     = 2;  // 0: positive error side, 1: negative
  localparam int unsigned SYNC_FLOPS = 2;
  localparam int unsigned WD_SHIFT  = 2;  // watchdog limit = H << WD_SHIFT
endpackage

// File: rtl/rtc_sync_edge.sv
`timescale 1ns/1ps
module rtc_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  // [STAGES-1] is the synchronized level, [STAGES] its one-cycle delay
  logic [STAGES:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-1:0], d_i};
  end

  assign q_o    = sr_q[STAGES-1];
  assign rise_o = sr_q[STAGES-1] & ~sr_q[STAGES];
  assign fall_o = ~sr_q[STAGES-1] & sr_q[STAGES];
endmodule

// File: rtl/rtc_dur_meter.sv
`timescale 1ns/1ps
module rtc_dur_meter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          seed_i,
  input  logic [CW-1:0] seed_val_i,
  input  logic          rise_i,
  input  logic          fall_i,
  output logic [CW-1:0] hi_len_o,
  output logic [CW-1:0] lo_len_o
);
  localparam logic [CW-1:0] SEG_MAX = '1;

  logic [CW-1:0] seg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q    <= '0;
      hi_len_o <= '0;
      lo_len_o <= '0;
    end else begin
      if (rise_i || fall_i)    seg_q <= CW'(1);
      else if (seg_q != SEG_MAX) seg_q <= seg_q + CW'(1);
      if (seed_i) begin
        hi_len_o <= seed_val_i;
        lo_len_o <= seed_val_i;
      end else begin
        if (fall_i) hi_len_o <= seg_q;
        if (rise_i) lo_len_o <= seg_q;
      end
    end
  end
endmodule

// File: rtl/rtc_ramp_div.sv
`timescale 1ns/1ps
module rtc_ramp_div #(
  parameter int unsigned CW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            cancel_i,
  input  logic [CW-1:0]   rate_i,
  input  logic [2*CW-1:0] thr_i,
  output logic            act_o,
  output logic            done_o,
  output logic [CW-1:0]   len_o
);
  localparam int unsigned   AW      = 2*CW + 1;
  localparam logic [CW-1:0] LEN_MAX = '1;

  logic [AW-1:0] acc_q;
  logic          hit;

  // ramp reaching threshold gives t = thr / rate without a divider
  assign hit    = act_o && (acc_q >= {1'b0, thr_i});
  assign done_o = hit && !cancel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o <= 1'b0;
      acc_q <= '0;
      len_o <= '0;
    end else if (start_i) begin
      act_o <= 1'b1;
      acc_q <= AW'(rate_i);
      len_o <= CW'(1);
    end else if (cancel_i || hit) begin
      act_o <= 1'b0;
    end else if (act_o) begin
      acc_q <= acc_q + AW'(rate_i);
      if (len_o != LEN_MAX) len_o <= len_o + CW'(1);
    end
  end
endmodule

// File: rtl/ramp_time_ctrl.sv
`timescale 1ns/1ps
module ramp_time_ctrl
  import rtc_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] half_period_i,
  input  logic          err_pol_i,
  output logic          sw_o
);
  localparam int unsigned WW = CW + WD_SHIFT;

  logic                        pol_s, pol_rise, pol_fall;
  logic                        seed_q;
  logic [CW-1:0]               ta_q, tb_q;
  logic [SIDES-1:0][CW-1:0]    hold_q;
  logic [SIDES-1:0][CW-1:0]    rate, len;
  logic [SIDES-1:0][2*CW-1:0]  thr;
  logic [SIDES-1:0]            start, cancel, done, ramp_act;
  logic [WW-1:0]               wd_q, wd_lim;
  logic                        wd_fire;

  rtc_sync_edge #(.STAGES(SYNC_FLOPS)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (err_pol_i),
    .q_o (pol_s), .rise_o (pol_rise), .fall_o (pol_fall)
  );

  rtc_dur_meter #(.CW(CW)) u_meter (
    .clk_i (clk_i), .rst_ni (rst_ni), .seed_i (seed_q),
    .seed_val_i (half_period_i), .rise_i (pol_rise), .fall_i (pol_fall),
    .hi_len_o (ta_q), .lo_len_o (tb_q)
  );

  assign start  = {pol_fall & ~sw_o, pol_rise & sw_o};
  assign cancel = {pol_rise | wd_fire, pol_fall | wd_fire};

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    assign rate[g] = (g == 0) ? ta_q : tb_q;
    assign thr[g]  = (2*CW)'(hold_q[g]) * (2*CW)'(half_period_i);
    rtc_ramp_div #(.CW(CW)) u_ramp (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .start_i (start[g]), .cancel_i (cancel[g]),
      .rate_i (rate[g]), .thr_i (thr[g]),
      .act_o (ramp_act[g]), .done_o (done[g]), .len_o (len[g])
    );
  end

  assign wd_lim  = {half_period_i, {WD_SHIFT{1'b0}}};
  // a real crossing in the same cycle takes precedence over the forced toggle
  assign wd_fire = (wd_q >= wd_lim - WW'(1)) && !(pol_rise || pol_fall);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seed_q <= 1'b1;
      hold_q <= '0;
      sw_o   <= 1'b0;
      wd_q   <= '0;
    end else begin
      seed_q <= 1'b0;
      if (seed_q) begin
        for (int i = 0; i < SIDES; i++) hold_q[i] <= half_period_i >> 1;
      end else begin
        for (int i = 0; i < SIDES; i++) if (done[i]) hold_q[i] <= len[i];
      end

      if (wd_fire)      sw_o <= ~sw_o;
      else if (done[0]) sw_o <= 1'b0;
      else if (done[1]) sw_o <= 1'b1;

      if (wd_fire || pol_rise || pol_fall || (|done)) wd_q <= '0;
      else                                            wd_q <= wd_q + WW'(1);
    end
  end
endmodule

// File: rtl/rtc_checker.sv
`timescale 1ns/1ps
module rtc_checker #(
  parameter int unsigned CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sw_i,
  input logic          pol_s_i,
  input logic [1:0]    act_i,
  input logic          wd_fire_i,
  input logic          seed_i,
  input logic [CW-1:0] ta_i,
  input logic [CW-1:0] tb_i
);
  p_fall_on_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_i) |-> ($past(pol_s_i) || $past(wd_fire_i)));

  p_rise_on_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_i) |-> (!$past(pol_s_i) || $past(wd_fire_i)));

  p_down_side_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i[0] |-> sw_i);

  p_up_side_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i[1] |-> !sw_i);

  p_rates_nonzero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seed_i |-> (ta_i != '0 && tb_i != '0));

  p_one_ramp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_i));
endmodule

bind ramp_time_ctrl rtc_checker #(.CW(CW)) u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .sw_i (sw_o), .pol_s_i (pol_s),
  .act_i (ramp_act), .wd_fire_i (wd_fire), .seed_i (seed_q),
  .ta_i (ta_q), .tb_i (tb_q)
);

// File: tb/ramp_time_ctrl_bench.sv
`timescale 1ns/1ps
module ramp_time_ctrl_bench;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] half = 16'd40;
  logic          man_pol = 1'b0;
  logic          plant_en = 1'b0;
  logic          plant_pol = 1'b0;
  logic          pol;
  logic          sw;

  int n_chk = 0;
  int n_bad = 0;
  int e = 0, pa = 1, pb = 1;
  int ta_m, tb_m, tar_m, tbf_m, h_m;

  assign pol = plant_en ? plant_pol : man_pol;

  always #2.5 clk = ~clk;

  ramp_time_ctrl #(.CW(CW)) u_ramp_time_ctrl (
    .clk_i (clk), .rst_ni (rst_n), .half_period_i (half),
    .err_pol_i (pol), .sw_o (sw)
  );

  // plant: error integrates up while the upper switch is on, clamped
  always @(negedge clk) begin
    if (plant_en) begin
      e = e + (sw ? pa : -pb);
      if (e > 100)  e = 100;
      if (e < -100) e = -100;
      plant_pol = (e > 0);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_near(input string tag, input int act, input int exp, input int tol);
    n_chk++;
    if (act > exp + tol || act < exp - tol) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d+-%0d", tag, act, exp, tol);
    end
  endtask

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  task automatic apply_reset(input int h);
    rst_n = 1'b0; plant_en = 1'b0; man_pol = 1'b0; half = CW'(h); h_m = h;
    ta_m = h; tb_m = h; tar_m = h / 2; tbf_m = h / 2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive a polarity edge that starts a ramp, check the toggle cycle exactly
  task automatic ramp_step(input logic v, input int prev_hold, input int hold, input string tag);
    int n;
    if (v) begin n = ceil_div(tar_m * h_m, ta_m); tb_m = prev_hold; end
    else   begin n = ceil_div(tbf_m * h_m, tb_m); ta_m = prev_hold; end
    man_pol = v;
    repeat (2 + n) @(negedge clk);
    chk({tag, " before toggle"}, int'(sw), int'(v));
    @(negedge clk);
    chk({tag, " at toggle"}, int'(sw), int'(!v));
    if (v) tar_m = n; else tbf_m = n;
    repeat (hold - 3 - n) @(negedge clk);
  endtask

  task automatic t_open;
    apply_reset(40);
    repeat (2) @(negedge clk);
    chk("R1 reset sw", int'(sw), 0);
    repeat (36) @(negedge clk);
    man_pol = 1'b1;               // first low span = 40 edges since release
    tb_m = 40;
    repeat (20) @(negedge clk);
    chk("R5 rise with sw low ignored", int'(sw), 0);
    ramp_step(1'b0, 20, 60, "R4 R1 R2 seeded up ramp");
    ramp_step(1'b1, 60, 50, "R3 R2 down ramp");
    ramp_step(1'b0, 50, 40, "R6 R4 measured up ramp");
    ramp_step(1'b1, 40, 64, "R3 R6 down ramp");
    ramp_step(1'b0, 64, 40, "R4 up ramp");
    ramp_step(1'b1, 40, 50, "R7 longer high span shortens delay");
    // up ramp of 14 would toggle 17 edges after the fall; cut it at 9
    man_pol = 1'b0;
    repeat (6) @(negedge clk);
    man_pol = 1'b1;
    repeat (20) @(negedge clk);
    chk("R10 cancelled ramp keeps sw", int'(sw), 0);
  endtask

  task automatic t_wd;
    apply_reset(40);
    repeat (159) @(negedge clk);
    chk("R8 before first forced toggle", int'(sw), 0);
    @(negedge clk);
    chk("R8 first forced toggle", int'(sw), 1);
    repeat (159) @(negedge clk);
    chk("R8 before second forced toggle", int'(sw), 1);
    @(negedge clk);
    chk("R8 second forced toggle", int'(sw), 0);
  endtask

  task automatic t_loop(input int h, input int a, input int b, input string tag);
    int cyc, hi, edges;
    logic prev;
    apply_reset(h);
    e = 0; pa = a; pb = b; plant_pol = 1'b0;
    plant_en = 1'b1;
    repeat (3000) @(negedge clk);
    prev = sw;
    while (!(sw && !prev)) begin prev = sw; @(negedge clk); end
    cyc = 0; hi = 0; edges = 0; prev = sw;
    while (edges < 16) begin
      @(negedge clk);
      cyc++;
      if (plant_pol) hi++;
      if (sw && !prev) edges++;
      prev = sw;
    end
    chk_near({tag, " period"}, cyc, 32 * h, 80);
    chk_near({tag, " high time"}, hi, 16 * h, 80);
    plant_en = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_open;
    t_wd;
    t_loop(40, 1, 1, "R9 equal slopes");
    t_loop(40, 1, 3, "R9 unequal slopes");
    t_loop(25, 2, 1, "R9 shorter period");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule